// File: doc/BRIEF.md
# Timer Interrupt Flag and Request Controller

This block holds the three event flags of an 8-bit timer/counter and turns them into interrupt requests. The counter side supplies one-cycle strobes for a match on compare channel A, a match on compare channel B, a wrap from the top count, and a direction reversal at count zero. A mode input selects which of the last two counts as the overflow event. In normal counting it is the wrap. In PWM (up/down) counting it is the reversal at zero.

Each flag can be cleared in two ways. The interrupt controller pulses a per-source acknowledge when it takes that vector, and software can write a one to the flag's bit. A separate enable (mask) register is written through its own port and reads back its stored value. A request line is high while the global enable, the source's enable bit and the source's flag are all 1.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset all flags and all enable bits are 0, both read ports return 0x00, and all three request lines are low.
- R2: The flag read value puts the overflow flag at bit 0, compare flag A at bit 1 and compare flag B at bit 2. Bits 7 to 3 of both read values are always 0.
- R3: A compare match strobe on channel A sets flag bit 1 at the next clock edge. A strobe on channel B sets flag bit 2 at the next clock edge.
- R4: With the mode input low (normal), a wrap strobe sets the overflow flag at the next edge, and the reversal-at-zero strobe has no effect on it.
- R5: With the mode input high (PWM), the reversal-at-zero strobe sets the overflow flag at the next edge, and the wrap strobe has no effect on it.
- R6: A flag-register write clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R7: An acknowledge strobe clears only its own source's flag, at the next edge.
- R8: When a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag is 1 afterwards.
- R9: Each request line is combinational from the registered flag, its enable bit and the global enable, and is high only when all three are 1.
- R10: Clearing an enable bit drops that source's request while its flag stays set.
- R11: The enable register uses bit 0 for overflow, bit 1 for compare A and bit 2 for compare B. A write updates it at the next edge, and it reads back with bits 7 to 3 at 0 whatever was written there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpMatchA | input | 1 | Compare channel A match strobe |
| cmpMatchB | input | 1 | Compare channel B match strobe |
| wrapEvt | input | 1 | Counter wrapped from its top value |
| bottomTurn | input | 1 | Counter reversed direction at zero |
| pwmMode | input | 1 | 1 selects up/down (PWM) overflow source |
| flagWrEn | input | 1 | Flag register write strobe |
| flagWrData | input | 8 | Flag write data, a 1 clears that flag |
| maskWrEn | input | 1 | Enable register write strobe |
| maskWrData | input | 8 | Enable register write data |
| globalIe | input | 1 | Global interrupt enable |
| ackOvf | input | 1 | Overflow vector taken |
| ackA | input | 1 | Compare A vector taken |
| ackB | input | 1 | Compare B vector taken |
| flagRd | output | 8 | Flag register read value |
| maskRd | output | 8 | Enable register read value |
| irqOvf | output | 1 | Overflow interrupt request |
| irqA | output | 1 | Compare A interrupt request |
| irqB | output | 1 | Compare B interrupt request |

## Verification
The hardest situation to reach is a set event landing on a flag in the same cycle as a write-one or an acknowledge, with the overflow source picked by the mode input, while the enable register changes underneath. The bench walks every combination of the thirteen single-bit stimulus fields, one combination per cycle, so collisions of set and clear occur in every mode and from both flag states. A bench model updates the flags and enables arithmetically and is compared with the read ports and request lines each cycle.

// File: rtl/timer_irq_pkg.sv
package timer_irq_pkg;
  localparam int SRC_N = 3;
  localparam int REG_W = 8;
  localparam int OVF_BIT = 0;
  localparam int CMPA_BIT = 1;
  localparam int CMPB_BIT = 2;

  typedef struct packed {
    logic [SRC_N-1:0] setVec;
    logic [SRC_N-1:0] clrVec;
    logic             maskLoad;
  } flagStrobes_t;
endpackage

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl
  import timer_irq_pkg::*;
(
  input  logic             cmpMatchA,
  input  logic             cmpMatchB,
  input  logic             wrapEvt,
  input  logic             bottomTurn,
  input  logic             pwmMode,
  input  logic             flagWrEn,
  input  logic [REG_W-1:0] flagWrData,
  input  logic             maskWrEn,
  input  logic [SRC_N-1:0] ackVec,
  output flagStrobes_t     strb
);
  logic ovfEvt;
  logic [SRC_N-1:0] swClr;

  // overflow source depends on counting mode
  assign ovfEvt = pwmMode ? bottomTurn : wrapEvt;
  assign swClr  = flagWrEn ? flagWrData[SRC_N-1:0] : '0;

  always_comb begin
    strb = '0;
    strb.setVec[OVF_BIT]  = ovfEvt;
    strb.setVec[CMPA_BIT] = cmpMatchA;
    strb.setVec[CMPB_BIT] = cmpMatchB;
    strb.clrVec           = swClr | ackVec;
    strb.maskLoad         = maskWrEn;
  end
endmodule

// File: rtl/timer_irq_dp.sv
module timer_irq_dp
  import timer_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobes_t     strb,
  input  logic [REG_W-1:0] maskWrData,
  input  logic             globalIe,
  output logic [SRC_N-1:0] flagQ,
  output logic [SRC_N-1:0] maskQ,
  output logic [SRC_N-1:0] irqVec
);
  localparam int PAD_W = REG_W - SRC_N;

  for (genvar i = 0; i < SRC_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 flagQ[i] <= 1'b0;
      else if (strb.setVec[i])   flagQ[i] <= 1'b1;
      else if (strb.clrVec[i])   flagQ[i] <= 1'b0;
    end

    assign irqVec[i] = globalIe & maskQ[i] & flagQ[i];

    // R8: a set in the same cycle as any clear leaves the flag high
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      strb.setVec[i] |=> flagQ[i]);
    // R6 / R7: a clear without a set drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.setVec[i] && strb.clrVec[i]) |=> !flagQ[i]);
    // R6: no strobe keeps the flag as it was
    a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.setVec[i] && !strb.clrVec[i]) |=> $stable(flagQ[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (strb.maskLoad) maskQ <= maskWrData[SRC_N-1:0];
  end

  // R11: a mask write is visible one edge later
  a_r11_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskLoad |=> (maskQ == $past(maskWrData[SRC_N-1:0])));

  logic unusedPad;
  assign unusedPad = ^maskWrData[REG_W-1:SRC_N] & (PAD_W > 0);
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import timer_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpMatchA,
  input  logic             cmpMatchB,
  input  logic             wrapEvt,
  input  logic             bottomTurn,
  input  logic             pwmMode,
  input  logic             flagWrEn,
  input  logic [REG_W-1:0] flagWrData,
  input  logic             maskWrEn,
  input  logic [REG_W-1:0] maskWrData,
  input  logic             globalIe,
  input  logic             ackOvf,
  input  logic             ackA,
  input  logic             ackB,
  output logic [REG_W-1:0] flagRd,
  output logic [REG_W-1:0] maskRd,
  output logic             irqOvf,
  output logic             irqA,
  output logic             irqB
);
  flagStrobes_t     strb;
  logic [SRC_N-1:0] ackVec, flagQ, maskQ, irqVec;

  always_comb begin
    ackVec = '0;
    ackVec[OVF_BIT]  = ackOvf;
    ackVec[CMPA_BIT] = ackA;
    ackVec[CMPB_BIT] = ackB;
  end

  timer_irq_ctrl ctrl_i (
    .cmpMatchA (cmpMatchA),
    .cmpMatchB (cmpMatchB),
    .wrapEvt   (wrapEvt),
    .bottomTurn(bottomTurn),
    .pwmMode   (pwmMode),
    .flagWrEn  (flagWrEn),
    .flagWrData(flagWrData),
    .maskWrEn  (maskWrEn),
    .ackVec    (ackVec),
    .strb      (strb)
  );

  timer_irq_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .maskWrData(maskWrData),
    .globalIe  (globalIe),
    .flagQ     (flagQ),
    .maskQ     (maskQ),
    .irqVec    (irqVec)
  );

  assign flagRd = {{(REG_W-SRC_N){1'b0}}, flagQ};
  assign maskRd = {{(REG_W-SRC_N){1'b0}}, maskQ};
  assign irqOvf = irqVec[OVF_BIT];
  assign irqA   = irqVec[CMPA_BIT];
  assign irqB   = irqVec[CMPB_BIT];

  // R2 / R11: unused read bits stay zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (flagRd[REG_W-1:SRC_N] == '0) && (maskRd[REG_W-1:SRC_N] == '0));
  // R5: in PWM mode a wrap alone cannot raise a clear overflow flag
  a_r5_pwm_ignores_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode && !bottomTurn && !flagRd[OVF_BIT]) |=> !flagRd[OVF_BIT]);
  // R4: in normal mode a bottom reversal alone cannot raise it
  a_r4_normal_ignores_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmMode && !wrapEvt && !flagRd[OVF_BIT]) |=> !flagRd[OVF_BIT]);
  // R7: acknowledge without a match clears compare flag A
  a_r7_ack_a_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ackA && !cmpMatchA) |=> !flagRd[CMPA_BIT]);
  // R3: a match on B always shows up as flag bit 2
  a_r3_match_b_sets: assert property (@(posedge clk) disable iff (!rstN)
    cmpMatchB |=> flagRd[CMPB_BIT]);
endmodule

// File: tb/timer_irq_flags_tb_top.sv
`timescale 1ns/1ps
module timer_irq_flags_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpMatchA = 0, cmpMatchB = 0, wrapEvt = 0, bottomTurn = 0, pwmMode = 0;
  logic flagWrEn = 0, maskWrEn = 0, globalIe = 0;
  logic [7:0] flagWrData = '0, maskWrData = '0;
  logic ackOvf = 0, ackA = 0, ackB = 0;
  logic [7:0] flagRd, maskRd;
  logic irqOvf, irqA, irqB;

  int nChecks = 0;
  int nFail = 0;
  logic [2:0] mFlag = '0;
  logic [2:0] mMask = '0;

  always #2 clk = ~clk;

  timer_irq_flags dut_i (
    .clk(clk), .rstN(rstN), .cmpMatchA(cmpMatchA), .cmpMatchB(cmpMatchB),
    .wrapEvt(wrapEvt), .bottomTurn(bottomTurn), .pwmMode(pwmMode),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .globalIe(globalIe), .ackOvf(ackOvf),
    .ackA(ackA), .ackB(ackB), .flagRd(flagRd), .maskRd(maskRd),
    .irqOvf(irqOvf), .irqA(irqA), .irqB(irqB)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    {cmpMatchA, cmpMatchB, wrapEvt, bottomTurn, flagWrEn, maskWrEn, ackOvf, ackA, ackB} = '0;
    flagWrData = '0;
    maskWrData = '0;
  endtask

  // apply current inputs for one edge, update model, return at next negedge
  task automatic stepModel();
    logic [2:0] setv, clrv;
    setv = {cmpMatchB, cmpMatchA, pwmMode ? bottomTurn : wrapEvt};
    clrv = (flagWrEn ? flagWrData[2:0] : 3'b0) | {ackB, ackA, ackOvf};
    @(posedge clk);
    mFlag = setv | (mFlag & ~clrv);
    if (maskWrEn) mMask = maskWrData[2:0];
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 flags", flagRd, 8'h00);
    chk("R1 mask", maskRd, 8'h00);
    globalIe = 1;
    #1 chk("R1 irqs", {5'b0, irqB, irqA, irqOvf}, 8'h00);
    rstN = 1;
    @(negedge clk);

    // R10 / R3: enable all, raise A, then mask it
    maskWrEn = 1; maskWrData = 8'hFF; stepModel(); clearIn();
    chk("R11 mask readback", maskRd, 8'h07);
    cmpMatchA = 1; stepModel(); clearIn();
    chk("R3 flag A bit1", flagRd, 8'h02);
    #1 chk("R10 irqA before mask", {7'b0, irqA}, 8'h01);
    maskWrEn = 1; maskWrData = 8'h05;
    #1 chk("R11 mask not yet applied", {7'b0, irqA}, 8'h01);
    stepModel(); clearIn();
    chk("R10 irqA masked", {7'b0, irqA}, 8'h00);
    chk("R10 flag kept", flagRd, 8'h02);
    // R8: match and ack together
    cmpMatchA = 1; ackA = 1; stepModel(); clearIn();
    chk("R8 set wins", flagRd, 8'h02);
    // R7: ack B does not touch A
    ackB = 1; stepModel(); clearIn();
    chk("R7 ack other source", flagRd, 8'h02);
    ackA = 1; stepModel(); clearIn();
    chk("R7 ack clears A", flagRd, 8'h00);

    // exhaustive sweep of the thirteen stimulus fields
    for (int v = 0; v < 8192; v++) begin
      logic [12:0] b;
      b = v[12:0];
      chk("R2 R3 R4 R5 R6 R7 R8 flags", flagRd, {5'b0, mFlag});
      chk("R11 mask", maskRd, {5'b0, mMask});
      cmpMatchA  = b[0];
      cmpMatchB  = b[1];
      wrapEvt    = b[2];
      bottomTurn = b[3];
      pwmMode    = b[4];
      flagWrEn   = b[5];
      flagWrData = {5'b10110, b[8:6]};
      {ackB, ackA, ackOvf} = b[11:9];
      maskWrEn   = b[12];
      maskWrData = {5'b10101, b[2:0] ^ b[11:9]};
      globalIe   = b[0] ^ b[12] ^ b[6] ^ b[9];
      #1 chk("R9 irqs", {5'b0, irqB, irqA, irqOvf}, {5'b0, mFlag & mMask & {3{globalIe}}});
      stepModel();
    end
    clearIn();
    chk("R2 R3 R4 R5 R6 R7 R8 final flags", flagRd, {5'b0, mFlag});

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule